// File: doc/BRIEF.md
# Auxiliary-Channel Native Request Engine

This block runs one native read or native write on a DisplayPort-style auxiliary channel from start to finish. A client gives a 16-bit target address, a direction and a byte count on a valid/ready request port. For a write, the client also gives up to 16 payload bytes. The engine packs a four-byte header in front of the payload and offers the message to a lower-level channel port. That port carries the message and answers with a channel status and a two-bit native reply code. The electrical signalling, hot-plug handling and wire-level timeout detection all sit below that port.

The engine sorts every answer into one of three groups:

- **Finishing outcomes.** Acknowledge, timeout, channel fault and refusal end the request.
- **Immediate retry.** A busy channel status sends the same message again on the next cycle.
- **Waited retry.** A defer reply holds the channel request low for a fixed time, then sends again. The wait is 400 µs, counted from a clock-frequency parameter.

Each request gets a fixed cap of four attempts. When the request ends, the engine pulses `done` for one cycle. It then shows a 3-bit result code, a transfer count and, for reads, the returned bytes. The returned byte count is clamped to the requested buffer length.

Back-pressure rules:

- `req_ready` is high only while the engine is idle. A request is taken on the cycle where `req_valid` and `req_ready` are both high.
- On the channel side, `ch_req_valid` stays high until `ch_req_ready` is seen. The message and its length do not change while it waits.
- `ch_rsp_ready` is high only while a reply is awaited. A response is taken when `ch_rsp_valid` is high in that state.

Top module: `aux_txn_engine`

## Requirements
- R1: Message byte 0 is the low address byte. Byte 1 is the high address byte. Byte 2 carries the command in its upper nibble (8 for native write, 9 for native read) and zero in its lower nibble. Byte i sits at `ch_msg[8*i+7:8*i]`.
- R2: In message byte 3, the upper nibble is the message length modulo 16 and the lower nibble is the transfer length minus one.
- R3: A write message is the payload length plus 4 bytes, with payload byte k at message byte 4+k. A read message is 4 bytes. Unused message bytes are zero, and `ch_msg_len` gives the length.
- R4: A request with length 0 or more than 16, in either direction, is refused. The engine pulses `done` on the next cycle with result 5 and issues no channel request.
- R5: A request makes at most 4 channel attempts. If busy or defer answers use up all 4, the result is 2 (I/O error).
- R6: Channel status 2 (busy) with attempts left raises `ch_req_valid` again on the cycle after the response, with no wait.
- R7: Channel status 1 (timeout) ends the request with result 1. Status 3 (channel fault) ends it with result 3. Neither is retried.
- R8: Status 0 with reply code 2'b10 (defer) and attempts left keeps `ch_req_valid` low for exactly WAIT_CYC = CLK_MHZ*DEFER_US cycles before the next attempt.
- R9: Status 0 with reply code 2'b00 (acknowledge) gives result 0. A write reports the payload length as its count. A read reports min(`ch_rx_count`, length), copies that many bytes and zeroes the rest of `rd_data`.
- R10: On status 0 with reply code 2'b01 or 2'b11, a read with `ch_rx_count` = 0 gives result 4 (protocol error). Any other such case, including every write, gives result 2.
- R11: `req_ready` is low from the accepting cycle until the cycle `done` is high. `done` lasts one cycle.
- R12: While `ch_req_valid` is high and `ch_req_ready` is low, `ch_req_valid`, `ch_msg` and `ch_msg_len` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_write | input | 1 | 1 = native write, 0 = native read |
| req_addr | input | 16 | Target address |
| req_len | input | LEN_W (5) | Byte count: payload length or read buffer size |
| req_wdata | input | MAX_BYTES*8 (128) | Write payload, byte k at bits 8k+7:8k |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 timeout, 2 I/O error, 3 channel fault, 4 protocol error, 5 refused |
| xfer_count | output | LEN_W (5) | Bytes transferred |
| rd_data | output | MAX_BYTES*8 (128) | Read bytes, zero beyond `xfer_count` |
| ch_req_valid | output | 1 | Message offered to the channel |
| ch_req_ready | input | 1 | Channel takes the message |
| ch_msg | output | (MAX_BYTES+4)*8 (160) | Header plus payload |
| ch_msg_len | output | MSG_W (5) | Message length in bytes |
| ch_rsp_valid | input | 1 | Channel answer present |
| ch_rsp_ready | output | 1 | Engine awaiting an answer |
| ch_status | input | 2 | 0 done, 1 timeout, 2 busy, 3 fault |
| ch_reply_code | input | 2 | 00 ack, 01 nack, 10 defer, 11 invalid |
| ch_rx_count | input | LEN_W (5) | Bytes returned by the channel |
| ch_rx_data | input | MAX_BYTES*8 (128) | Returned bytes |

## Verification
The bench sweeps every legal length in both directions and checks every header byte. A design with a dropped length nibble, or one that does not truncate a 20-byte message length to its low nibble, fails there. Retry sequences measure the cycle gap before each new attempt. Any wait added after a busy status shows up in that gap, as does a defer wait that is off by one cycle or skipped. Further tests probe:

- the fifth-attempt cutoff;
- the split between protocol error and I/O error on an empty read;
- clamping when the channel returns more bytes than asked;
- refusal of lengths 0, 17 and 31 with no channel traffic.

// File: rtl/aux_txn_pkg.sv
package aux_txn_pkg;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_TIMEOUT = 3'd1,
    RES_IOERR   = 3'd2,
    RES_CHFAULT = 3'd3,
    RES_PROTO   = 3'd4,
    RES_REFUSED = 3'd5
  } aux_res_e;

  typedef enum logic [1:0] {
    ACT_FINISH     = 2'd0,
    ACT_RETRY_NOW  = 2'd1,
    ACT_RETRY_WAIT = 2'd2
  } aux_act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_RESP = 2'd2,
    ST_WAIT = 2'd3
  } aux_state_e;

  localparam logic [1:0] CH_DONE    = 2'd0;
  localparam logic [1:0] CH_TIMEOUT = 2'd1;
  localparam logic [1:0] CH_BUSY    = 2'd2;
  localparam logic [1:0] CH_FAULT   = 2'd3;

  localparam logic [1:0] RPL_ACK   = 2'b00;
  localparam logic [1:0] RPL_DEFER = 2'b10;

  localparam logic [3:0] CMD_NATIVE_WR = 4'h8;
  localparam logic [3:0] CMD_NATIVE_RD = 4'h9;

endpackage

// File: rtl/aux_msg_build.sv
module aux_msg_build #(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 5,
  parameter int MSG_W     = 5
) (
  input  logic                       is_write,
  input  logic [15:0]                addr,
  input  logic [LEN_W-1:0]           len,
  input  logic [MAX_BYTES*8-1:0]     payload,
  output logic [(MAX_BYTES+4)*8-1:0] msg,
  output logic [MSG_W-1:0]           msg_len
);
  import aux_txn_pkg::*;

  logic [LEN_W-1:0] len_m1;
  logic [MSG_W-1:0] total;

  always_comb begin
    len_m1 = len - LEN_W'(1);
    total  = is_write ? (MSG_W'(len) + MSG_W'(4)) : MSG_W'(4);
  end

  assign msg_len       = total;
  assign msg[7:0]      = addr[7:0];
  assign msg[15:8]     = addr[15:8];
  assign msg[23:16]    = {(is_write ? CMD_NATIVE_WR : CMD_NATIVE_RD), 4'h0};
  assign msg[31:24]    = {total[3:0], len_m1[3:0]};

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_pay
    assign msg[(4+k)*8 +: 8] = (is_write && (LEN_W'(k) < len)) ? payload[k*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/aux_reply_class.sv
module aux_reply_class #(
  parameter int LEN_W = 5
) (
  input  logic [1:0]       status,
  input  logic [1:0]       reply_code,
  input  logic [LEN_W-1:0] rx_count,
  input  logic             is_write,
  input  logic             last_try,
  output aux_txn_pkg::aux_act_e act,
  output aux_txn_pkg::aux_res_e res
);
  import aux_txn_pkg::*;

  always_comb begin
    act = ACT_FINISH;
    res = RES_IOERR;
    case (status)
      CH_TIMEOUT: res = RES_TIMEOUT;
      CH_FAULT:   res = RES_CHFAULT;
      CH_BUSY:    if (!last_try) act = ACT_RETRY_NOW;
      default: begin
        if (reply_code == RPL_ACK) begin
          res = RES_OK;
        end else if (reply_code == RPL_DEFER) begin
          if (!last_try) act = ACT_RETRY_WAIT;
        end else if (!is_write && (rx_count == '0)) begin
          res = RES_PROTO;
        end
      end
    endcase
  end

endmodule

// File: rtl/aux_rx_clamp.sv
module aux_rx_clamp #(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 5
) (
  input  logic [MAX_BYTES*8-1:0] rx_data,
  input  logic [LEN_W-1:0]       rx_count,
  input  logic [LEN_W-1:0]       limit,
  output logic [LEN_W-1:0]       count,
  output logic [MAX_BYTES*8-1:0] data
);

  assign count = (rx_count > limit) ? limit : rx_count;

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_mask
    assign data[k*8 +: 8] = (LEN_W'(k) < count) ? rx_data[k*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
  parameter int WAIT_CYC = 100000,
  localparam int WAIT_W  = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);

  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= WAIT_W'(WAIT_CYC);
    end else if (run && (cnt != '0)) begin
      cnt <= cnt - WAIT_W'(1);
    end
  end

  assign expire = run && (cnt <= WAIT_W'(1));

endmodule

// File: rtl/aux_txn_engine.sv
module aux_txn_engine #(
  parameter int MAX_BYTES  = 16,
  parameter int MAX_TRIES  = 4,
  parameter int CLK_MHZ    = 250,
  parameter int DEFER_US   = 400,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int MSG_BYTES = MAX_BYTES + 4,
  localparam int MSG_W     = $clog2(MSG_BYTES + 1),
  localparam int TRY_W     = $clog2(MAX_TRIES + 1),
  localparam int WAIT_CYC  = CLK_MHZ * DEFER_US
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [15:0]            req_addr,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [MAX_BYTES*8-1:0] req_wdata,
  output logic                   done,
  output logic [2:0]             result,
  output logic [LEN_W-1:0]       xfer_count,
  output logic [MAX_BYTES*8-1:0] rd_data,
  output logic                   ch_req_valid,
  input  logic                   ch_req_ready,
  output logic [MSG_BYTES*8-1:0] ch_msg,
  output logic [MSG_W-1:0]       ch_msg_len,
  input  logic                   ch_rsp_valid,
  output logic                   ch_rsp_ready,
  input  logic [1:0]             ch_status,
  input  logic [1:0]             ch_reply_code,
  input  logic [LEN_W-1:0]       ch_rx_count,
  input  logic [MAX_BYTES*8-1:0] ch_rx_data
);
  import aux_txn_pkg::*;

  aux_state_e             state;
  logic                   wr_q;
  logic [15:0]            addr_q;
  logic [LEN_W-1:0]       len_q;
  logic [MAX_BYTES*8-1:0] pay_q;
  logic [TRY_W-1:0]       tries;
  logic                   done_q;
  aux_res_e               res_q;
  logic [LEN_W-1:0]       cnt_q;
  logic [MAX_BYTES*8-1:0] rd_q;

  aux_act_e               act;
  aux_res_e               cls_res;
  logic                   last_try;
  logic                   len_bad;
  logic                   rsp_take;
  logic                   wait_done;
  logic [LEN_W-1:0]       clamp_cnt;
  logic [MAX_BYTES*8-1:0] clamp_data;

  assign len_bad  = (req_len == '0) || (req_len > LEN_W'(MAX_BYTES));
  assign last_try = (tries >= TRY_W'(MAX_TRIES));
  assign rsp_take = (state == ST_RESP) && ch_rsp_valid;

  aux_msg_build #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .MSG_W(MSG_W)) u_build (
    .is_write (wr_q),
    .addr     (addr_q),
    .len      (len_q),
    .payload  (pay_q),
    .msg      (ch_msg),
    .msg_len  (ch_msg_len)
  );

  aux_reply_class #(.LEN_W(LEN_W)) u_class (
    .status     (ch_status),
    .reply_code (ch_reply_code),
    .rx_count   (ch_rx_count),
    .is_write   (wr_q),
    .last_try   (last_try),
    .act        (act),
    .res        (cls_res)
  );

  aux_rx_clamp #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_clamp (
    .rx_data  (ch_rx_data),
    .rx_count (ch_rx_count),
    .limit    (len_q),
    .count    (clamp_cnt),
    .data     (clamp_data)
  );

  aux_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (rsp_take && (act == ACT_RETRY_WAIT)),
    .run    (state == ST_WAIT),
    .expire (wait_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      wr_q   <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      pay_q  <= '0;
      tries  <= '0;
      done_q <= 1'b0;
      res_q  <= RES_OK;
      cnt_q  <= '0;
      rd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q   <= req_write;
            addr_q <= req_addr;
            len_q  <= req_len;
            pay_q  <= req_wdata;
            tries  <= '0;
            if (len_bad) begin
              done_q <= 1'b1;
              res_q  <= RES_REFUSED;
              cnt_q  <= '0;
              rd_q   <= '0;
            end else begin
              state <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (ch_req_ready) begin
            state <= ST_RESP;
            tries <= tries + TRY_W'(1);
          end
        end
        ST_RESP: begin
          if (ch_rsp_valid) begin
            case (act)
              ACT_RETRY_NOW:  state <= ST_SEND;
              ACT_RETRY_WAIT: state <= ST_WAIT;
              default: begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
                res_q  <= cls_res;
                if (cls_res == RES_OK) begin
                  cnt_q <= wr_q ? len_q : clamp_cnt;
                  rd_q  <= wr_q ? '0 : clamp_data;
                end else begin
                  cnt_q <= '0;
                  rd_q  <= '0;
                end
              end
            endcase
          end
        end
        default: begin
          if (wait_done) state <= ST_SEND;
        end
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign ch_req_valid = (state == ST_SEND);
  assign ch_rsp_ready = (state == ST_RESP);
  assign done         = done_q;
  assign result       = res_q;
  assign xfer_count   = cnt_q;
  assign rd_data      = rd_q;

endmodule

// File: rtl/aux_txn_engine_chk.sv
module aux_txn_engine_chk #(
  parameter int MAX_BYTES = 16,
  parameter int MAX_TRIES = 4,
  parameter int LEN_W     = 5,
  parameter int MSG_BYTES = 20,
  parameter int MSG_W     = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [LEN_W-1:0]       req_len,
  input logic                   done,
  input logic [2:0]             result,
  input logic [LEN_W-1:0]       xfer_count,
  input logic                   ch_req_valid,
  input logic                   ch_req_ready,
  input logic [MSG_BYTES*8-1:0] ch_msg,
  input logic [MSG_W-1:0]       ch_msg_len,
  input logic                   ch_rsp_valid,
  input logic                   ch_rsp_ready,
  input logic [1:0]             ch_status,
  input logic [1:0]             ch_reply_code
);
  localparam int CW = $clog2(MAX_TRIES + 2) + 1;

  logic [CW-1:0] n_tries;
  logic          rsp_hs;

  assign rsp_hs = ch_rsp_valid && ch_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) n_tries <= '0;
    else if (req_valid && req_ready) n_tries <= '0;
    else if (ch_req_valid && ch_req_ready) n_tries <= n_tries + CW'(1);
  end

  AST_REFUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ((req_len == '0) || (req_len > LEN_W'(MAX_BYTES))))
      |=> (done && (result == 3'd5) && !ch_req_valid)); // R4

  AST_TRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    n_tries <= CW'(MAX_TRIES)); // R5

  AST_BUSY_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hs && (ch_status == 2'd2) && (n_tries < CW'(MAX_TRIES))) |=> ch_req_valid); // R6

  AST_HARD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hs && ((ch_status == 2'd1) || (ch_status == 2'd3)))
      |=> (done && !ch_req_valid && (result == {1'b0, $past(ch_status)}))); // R7

  AST_DEFER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hs && (ch_status == 2'd0) && (ch_reply_code == 2'b10) && (n_tries < CW'(MAX_TRIES)))
      |=> (!ch_req_valid && !done)); // R8

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (result == 3'd0)) |-> (xfer_count <= LEN_W'(MAX_BYTES))); // R9

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req_valid || ch_rsp_ready) |-> !req_ready); // R11

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req_valid && !ch_req_ready)
      |=> (ch_req_valid && $stable(ch_msg) && $stable(ch_msg_len))); // R12

endmodule

bind aux_txn_engine aux_txn_engine_chk #(
  .MAX_BYTES (MAX_BYTES),
  .MAX_TRIES (MAX_TRIES),
  .LEN_W     (LEN_W),
  .MSG_BYTES (MSG_BYTES),
  .MSG_W     (MSG_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_len       (req_len),
  .done          (done),
  .result        (result),
  .xfer_count    (xfer_count),
  .ch_req_valid  (ch_req_valid),
  .ch_req_ready  (ch_req_ready),
  .ch_msg        (ch_msg),
  .ch_msg_len    (ch_msg_len),
  .ch_rsp_valid  (ch_rsp_valid),
  .ch_rsp_ready  (ch_rsp_ready),
  .ch_status     (ch_status),
  .ch_reply_code (ch_reply_code)
);

// File: tb/aux_txn_engine_tb.sv
`timescale 1ns/1ps
module aux_txn_engine_tb;
  localparam int MAXB  = 16;
  localparam int WAITC = 250;
  localparam int LW    = 5;
  localparam int MB    = 20;
  localparam int MW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [MAXB*8-1:0] req_wdata = '0;
  logic done;
  logic [2:0] result;
  logic [LW-1:0] xfer_count;
  logic [MAXB*8-1:0] rd_data;
  logic ch_req_valid, ch_req_ready = 1'b0;
  logic [MB*8-1:0] ch_msg;
  logic [MW-1:0] ch_msg_len;
  logic ch_rsp_valid = 1'b0, ch_rsp_ready;
  logic [1:0] ch_status = '0, ch_reply_code = '0;
  logic [LW-1:0] ch_rx_count = '0;
  logic [MAXB*8-1:0] ch_rx_data;

  aux_txn_engine #(.MAX_BYTES(MAXB), .MAX_TRIES(4), .CLK_MHZ(250), .DEFER_US(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .done(done), .result(result), .xfer_count(xfer_count), .rd_data(rd_data),
    .ch_req_valid(ch_req_valid), .ch_req_ready(ch_req_ready), .ch_msg(ch_msg),
    .ch_msg_len(ch_msg_len), .ch_rsp_valid(ch_rsp_valid), .ch_rsp_ready(ch_rsp_ready),
    .ch_status(ch_status), .ch_reply_code(ch_reply_code), .ch_rx_count(ch_rx_count),
    .ch_rx_data(ch_rx_data)
  );

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  for (genvar i = 0; i < MAXB; i++) begin : g_rx
    assign ch_rx_data[i*8 +: 8] = 8'hC0 + 8'(i);
  end

  // channel model state
  int n_att = 0, stall = 0, acc_cyc = 0;
  int gap [8];
  logic [1:0] scr_st [4];
  logic [1:0] scr_rp [4];
  logic [LW-1:0] scr_ct [4];
  logic [MB*8-1:0] first_msg;
  logic [MW-1:0] first_len;
  bit hold_bad = 0, busy_bad = 0;
  logic [2:0] got_res;
  logic [LW-1:0] got_cnt;
  logic [MAXB*8-1:0] got_rd;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic script(input int k, input logic [1:0] st, input logic [1:0] rp, input int ct);
    scr_st[k] = st; scr_rp[k] = rp; scr_ct[k] = ct[LW-1:0];
  endtask

  task automatic script_all(input logic [1:0] st, input logic [1:0] rp, input int ct);
    for (int k = 0; k < 4; k++) script(k, st, rp, ct);
  endtask

  // responder
  initial begin
    @(negedge clk);
    forever begin
      if (ch_req_valid) begin
        if (n_att < 8) gap[n_att] = cyc - acc_cyc;
        if (n_att == 0) begin first_msg = ch_msg; first_len = ch_msg_len; end
        for (int s = 0; s < stall && n_att == 0; s++) begin
          @(negedge clk);
          if (!ch_req_valid || ch_msg != first_msg || ch_msg_len != first_len) hold_bad = 1;
        end
        ch_req_ready = 1'b1;
        @(negedge clk);
        ch_req_ready = 1'b0;
        if (n_att < 4) begin
          ch_status = scr_st[n_att]; ch_reply_code = scr_rp[n_att]; ch_rx_count = scr_ct[n_att];
        end else begin
          ch_status = 2'd0; ch_reply_code = 2'b00; ch_rx_count = '0;
        end
        n_att++;
        ch_rsp_valid = 1'b1;
        @(negedge clk);
        ch_rsp_valid = 1'b0;
        acc_cyc = cyc;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic run_txn(input bit w, input logic [15:0] a, input int len, input int stl);
    int k;
    n_att = 0; stall = stl; hold_bad = 0; busy_bad = 0;
    for (int g = 0; g < 8; g++) gap[g] = -1;
    req_write = w; req_addr = a; req_len = len[LW-1:0];
    for (int b = 0; b < MAXB; b++) req_wdata[b*8 +: 8] = 8'((b * 37 + len * 5) & 255);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (!done && k < 3000) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      k++;
    end
    got_res = result; got_cnt = xfer_count; got_rd = rd_data;
    @(negedge clk);
  endtask

  task automatic check_msg(input bit w, input logic [15:0] a, input int len, input string tag);
    int exp_len, bad;
    logic [7:0] eb;
    exp_len = w ? len + 4 : 4;
    bad = -1;
    for (int b = 0; b < MB; b++) begin
      case (b)
        0: eb = a[7:0];
        1: eb = a[15:8];
        2: eb = w ? 8'h80 : 8'h90;
        3: eb = {4'(exp_len & 15), 4'((len - 1) & 15)};
        default: eb = (w && (b - 4) < len) ? 8'(((b - 4) * 37 + len * 5) & 255) : 8'h00;
      endcase
      if (first_msg[b*8 +: 8] != eb && bad < 0) bad = b;
    end
    chk(bad < 0, {tag, " header/payload byte mismatch index"}, bad, -1);
    chk(first_len == MW'(exp_len), {tag, " R3 message length"}, first_len, exp_len);
  endtask

  initial begin
    int expc, rx, bad;
    logic [15:0] a;
    repeat (3) @(negedge clk);
    // reset state (R11)
    chk(done == 1'b0, "R11 reset done low", done, 0);
    chk(ch_req_valid == 1'b0, "R11 reset no channel request", ch_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 idle ready", req_ready, 1);

    // R1 R2 R3 R9: write sweep, every legal length, acknowledged
    for (int len = 1; len <= 16; len++) begin
      a = 16'(16'h1234 ^ (len * 16'h0907));
      script_all(2'd0, 2'b00, 0);
      run_txn(1'b1, a, len, 0);
      check_msg(1'b1, a, len, "R1 R2 write");
      chk(got_res == 3'd0, "R9 write ack result", got_res, 0);
      chk(got_cnt == LW'(len), "R9 write count", got_cnt, len);
      chk(n_att == 1, "R5 single attempt", n_att, 1);
      chk(!busy_bad, "R11 ready low while busy", busy_bad, 0);
    end

    // R1 R2 R3 R9: read sweep with clamping
    for (int len = 1; len <= 16; len++) begin
      a = 16'(16'hA5C3 + len * 16'h0111);
      rx = (len * 7) % 17;
      expc = (rx < len) ? rx : len;
      script_all(2'd0, 2'b00, rx);
      run_txn(1'b0, a, len, 0);
      check_msg(1'b0, a, len, "R1 R2 read");
      chk(got_res == 3'd0, "R9 read ack result", got_res, 0);
      chk(got_cnt == LW'(expc), "R9 read clamped count", got_cnt, expc);
      bad = -1;
      for (int b = 0; b < MAXB; b++)
        if (got_rd[b*8 +: 8] != ((b < expc) ? 8'hC0 + 8'(b) : 8'h00) && bad < 0) bad = b;
      chk(bad < 0, "R9 read data bytes mismatch index", bad, -1);
    end

    // R4: refused lengths
    script_all(2'd0, 2'b00, 0);
    run_txn(1'b1, 16'h0001, 0, 0);
    chk(got_res == 3'd5 && n_att == 0, "R4 write len 0 refused", {got_res, 8'(n_att)}, 5 << 8);
    run_txn(1'b1, 16'h0002, 17, 0);
    chk(got_res == 3'd5 && n_att == 0, "R4 write len 17 refused", {got_res, 8'(n_att)}, 5 << 8);
    run_txn(1'b0, 16'h0003, 0, 0);
    chk(got_res == 3'd5 && n_att == 0, "R4 read len 0 refused", {got_res, 8'(n_att)}, 5 << 8);
    run_txn(1'b0, 16'h0004, 31, 0);
    chk(got_res == 3'd5 && n_att == 0, "R4 read len 31 refused", {got_res, 8'(n_att)}, 5 << 8);

    // R6: three busy then ack
    script(0, 2'd2, 2'b00, 0); script(1, 2'd2, 2'b00, 0); script(2, 2'd2, 2'b00, 0);
    script(3, 2'd0, 2'b00, 0);
    run_txn(1'b1, 16'h4400, 2, 0);
    chk(got_res == 3'd0 && n_att == 4, "R6 busy x3 then ack", {got_res, 8'(n_att)}, 4);
    chk(gap[1] == 0 && gap[2] == 0 && gap[3] == 0, "R6 busy retry gap", gap[3], 0);

    // R5: four busy exhaust
    script_all(2'd2, 2'b00, 0);
    run_txn(1'b0, 16'h4401, 4, 0);
    chk(got_res == 3'd2 && n_att == 4, "R5 busy exhaust", {got_res, 8'(n_att)}, (2 << 8) | 4);

    // R8: defer then ack
    script(0, 2'd0, 2'b10, 0); script(1, 2'd0, 2'b00, 3);
    run_txn(1'b0, 16'h5500, 3, 0);
    chk(got_res == 3'd0 && n_att == 2, "R8 defer then ack", {got_res, 8'(n_att)}, 2);
    chk(gap[1] == WAITC, "R8 defer wait cycles", gap[1], WAITC);

    // R5 R8: defer exhaust
    script_all(2'd0, 2'b10, 0);
    run_txn(1'b1, 16'h5501, 1, 0);
    chk(got_res == 3'd2 && n_att == 4, "R5 defer exhaust", {got_res, 8'(n_att)}, (2 << 8) | 4);
    chk(gap[3] == WAITC, "R8 defer wait on later attempt", gap[3], WAITC);

    // R7: timeout and fault
    script_all(2'd1, 2'b00, 0);
    run_txn(1'b0, 16'h6600, 2, 0);
    chk(got_res == 3'd1 && n_att == 1, "R7 timeout no retry", {got_res, 8'(n_att)}, (1 << 8) | 1);
    script_all(2'd3, 2'b00, 0);
    run_txn(1'b1, 16'h6601, 2, 0);
    chk(got_res == 3'd3 && n_att == 1, "R7 fault no retry", {got_res, 8'(n_att)}, (3 << 8) | 1);

    // R10: non-ack non-defer replies
    script_all(2'd0, 2'b01, 0);
    run_txn(1'b0, 16'h7700, 4, 0);
    chk(got_res == 3'd4 && n_att == 1, "R10 read nack empty", got_res, 4);
    script_all(2'd0, 2'b01, 2);
    run_txn(1'b0, 16'h7701, 4, 0);
    chk(got_res == 3'd2, "R10 read nack with bytes", got_res, 2);
    script_all(2'd0, 2'b01, 0);
    run_txn(1'b1, 16'h7702, 4, 0);
    chk(got_res == 3'd2, "R10 write nack", got_res, 2);
    script_all(2'd0, 2'b11, 0);
    run_txn(1'b0, 16'h7703, 1, 0);
    chk(got_res == 3'd4, "R10 read invalid reply empty", got_res, 4);

    // R12: back-pressure on the channel request
    script_all(2'd0, 2'b00, 0);
    run_txn(1'b1, 16'h8800, 5, 3);
    chk(!hold_bad, "R12 request held under back-pressure", hold_bad, 0);
    check_msg(1'b1, 16'h8800, 5, "R12 stalled write");
    chk(got_res == 3'd0, "R12 stalled write result", got_res, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule